// File: doc/BRIEF.md
# I2C Master Transmitter with Programmable Bit Count

This block is the transmit side of an I2C bus master. A START command takes the idle bus: SDA falls while SCL is high, and SCL is then held low. Each write of the data register starts one transfer and raises a pending flag. The block shifts the selected number of data bits out on SDA, most significant first. It clocks them with an SCL that it derives from the system clock through a programmable half-period divider.

The data length comes from a small bit-count field, and an optional acknowledge clock can follow the data. The receiver's acknowledge level is stored as the last received bit. A 1 there means the receiver wants no further data, and software should then issue STOP. When a transfer ends, the pending flag clears, a one-cycle interrupt pulse is raised, and SCL stays low until the next write or a STOP. A STOP raises SCL with SDA low, then releases SDA, which returns the bus to idle.

Top module: `i2c_mtx`

## Requirements
- R1: After reset, scl_o = 1, sda_o = 1, pending_o = 0, irq_o = 0, lrb_o = 0 and err_o = 0.
- R2: In idle, a start_i pulse drives sda_o low while scl_o stays high for div_i+1 clocks. Then scl_o goes low with sda_o low and stays low. start_i is ignored in any state other than idle.
- R3: In the held state (after START or a finished transfer), a data_we_i pulse sets pending_o in the next cycle. It sends the selected data bits one per SCL high phase, and sda_o never changes while scl_o stays high during a transfer.
- R4: Field bit_cnt_i = 0 selects 8 bits, and values 1 to 7 select that many bits. The bits sent are data_i[n-1:0], with bit n-1 first.
- R5: With ack_en_i = 1 at the write, one extra SCL clock follows the data with sda_o released (1). The sda_i level at the end of its high phase is stored in lrb_o (1 = no acknowledge). With ack_en_i = 0, lrb_o keeps its value.
- R6: Every SCL low or high phase of a transfer lasts div_i+1 clocks, so pending_o stays high for 2*(n+ack)*(div_i+1) clocks.
- R7: At the end of a transfer, pending_o clears and irq_o is high for exactly that one cycle. scl_o then stays low until the next write or a STOP.
- R8: A data_we_i pulse while pending_o = 1, or outside the held state, is ignored and sets err_o, which stays set until reset. The running transfer is not altered.
- R9: In the held state, stop_i drives SCL low for one phase, then high with SDA low for one phase, then SDA high, which returns both lines to 1 in idle. stop_i is ignored while pending_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | SCL half-period length minus one, in clocks |
| bit_cnt_i | input | BC_W | Bits per transfer, 0 means DATA_W |
| ack_en_i | input | 1 | Add an acknowledge clock after the data |
| start_i | input | 1 | START command pulse |
| stop_i | input | 1 | STOP command pulse |
| data_we_i | input | 1 | Data register write strobe |
| data_i | input | DATA_W | Data to transmit |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level (1 = released) |
| pending_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Transfer-complete pulse |
| lrb_o | output | 1 | Last acknowledge level received |
| err_o | output | 1 | Sticky ignored-write error |

## Verification
A bad remaining-bit count or a shifter misaligned by the bit-count field shows up within one transfer. It appears as the wrong number of SCL rising edges or the wrong bit pattern captured at those edges. A phase counter that ends a phase early or late changes the length of the pending window and the START and STOP phases by whole multiples of a clock, and this is visible at the end of the first phase. A controller state that drifts shows up within a cycle or two. It appears as SDA moving during an SCL high phase, a missing or doubled interrupt, or SCL released while the bus should be held.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_HOLD,
    ST_BLO,
    ST_BHI,
    ST_ALO,
    ST_AHI,
    ST_PLO,
    ST_PHI,
    ST_PEND
  } mst_state_e;
endpackage

// File: rtl/i2c_mtx_timer.sv
module i2c_mtx_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps a mid-phase divider change from wrapping the counter
  assign tick_o = run_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_mtx_shift.sv
module i2c_mtx_shift #(
  parameter int DATA_W = 8,
  parameter int BC_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BC_W-1:0]   bc_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int REM_W = BC_W + 1;

  logic [DATA_W-1:0] sr_q;
  logic [REM_W-1:0]  rem_q;
  logic [REM_W-1:0]  len;

  assign len    = (bc_i == '0) ? REM_W'(DATA_W) : REM_W'(bc_i);
  assign bit_o  = sr_q[DATA_W-1];
  assign last_o = (rem_q == REM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      // left-align the low len bits so the MSB path is fixed
      sr_q  <= data_i << (REM_W'(DATA_W) - len);
      rem_q <= len;
    end else if (shift_i) begin
      sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
      rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/i2c_mtx_ctrl.sv
module i2c_mtx_ctrl
  import i2c_mtx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic we_i,
  input  logic ack_en_i,
  input  logic tick_i,
  input  logic last_i,
  input  logic bit_i,
  input  logic sda_i,
  output logic run_o,
  output logic load_o,
  output logic shift_o,
  output logic scl_o,
  output logic sda_o,
  output logic pending_o,
  output logic irq_o,
  output logic lrb_o,
  output logic err_o
);
  mst_state_e state_q, state_d;
  logic ack_q, irq_q, lrb_q, err_q;
  logic done;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_START;
      ST_START: if (tick_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (we_i) begin
          state_d = ST_BLO;
          load_o  = 1'b1;
        end else if (stop_i) begin
          state_d = ST_PLO;
        end
      end
      ST_BLO:   if (tick_i) state_d = ST_BHI;
      ST_BHI: begin
        if (tick_i) begin
          if (!last_i) begin
            state_d = ST_BLO;
            shift_o = 1'b1;
          end else if (ack_q) begin
            state_d = ST_ALO;
          end else begin
            state_d = ST_HOLD;
            done    = 1'b1;
          end
        end
      end
      ST_ALO:   if (tick_i) state_d = ST_AHI;
      ST_AHI: begin
        if (tick_i) begin
          state_d = ST_HOLD;
          done    = 1'b1;
        end
      end
      ST_PLO:   if (tick_i) state_d = ST_PHI;
      ST_PHI:   if (tick_i) state_d = ST_PEND;
      ST_PEND:  if (tick_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      irq_q   <= 1'b0;
      lrb_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= done;
      if (load_o) ack_q <= ack_en_i;
      if (state_q == ST_AHI && tick_i) lrb_q <= sda_i;
      if (we_i && !load_o) err_q <= 1'b1;
    end
  end

  assign run_o     = !(state_q inside {ST_IDLE, ST_HOLD});
  assign pending_o = state_q inside {ST_BLO, ST_BHI, ST_ALO, ST_AHI};
  assign scl_o     = state_q inside {ST_IDLE, ST_START, ST_BHI, ST_AHI, ST_PHI, ST_PEND};

  always_comb begin
    unique case (state_q)
      ST_IDLE, ST_PEND, ST_ALO, ST_AHI: sda_o = 1'b1;
      ST_BLO, ST_BHI:                   sda_o = bit_i;
      default:                          sda_o = 1'b0;
    endcase
  end

  assign irq_o = irq_q;
  assign lrb_o = lrb_q;
  assign err_o = err_q;
endmodule

// File: rtl/i2c_mtx.sv
module i2c_mtx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  localparam int BC_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [BC_W-1:0]   bit_cnt_i,
  input  logic              ack_en_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              pending_o,
  output logic              irq_o,
  output logic              lrb_o,
  output logic              err_o
);
  logic run, tick, load, shift, tx_bit, last_bit;

  i2c_mtx_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .tick_o (tick)
  );

  i2c_mtx_shift #(.DATA_W(DATA_W), .BC_W(BC_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .data_i  (data_i),
    .bc_i    (bit_cnt_i),
    .bit_o   (tx_bit),
    .last_o  (last_bit)
  );

  i2c_mtx_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .we_i      (data_we_i),
    .ack_en_i  (ack_en_i),
    .tick_i    (tick),
    .last_i    (last_bit),
    .bit_i     (tx_bit),
    .sda_i     (sda_i),
    .run_o     (run),
    .load_o    (load),
    .shift_o   (shift),
    .scl_o     (scl_o),
    .sda_o     (sda_o),
    .pending_o (pending_o),
    .irq_o     (irq_o),
    .lrb_o     (lrb_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/i2c_mtx_chk.sv
module i2c_mtx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic data_we_i,
  input logic scl_o,
  input logic sda_o,
  input logic pending_o,
  input logic irq_o,
  input logic lrb_o,
  input logic err_o
);
  // R3
  sda_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && pending_o && $past(pending_o)) |-> $stable(sda_o));

  // R3
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_o) |-> $past(data_we_i));

  // R7
  irq_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!pending_o && $past(pending_o)));

  // R5
  lrb_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrb_o) |-> irq_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R8
  err_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && pending_o) |=> err_o);
endmodule

bind i2c_mtx i2c_mtx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_we_i (data_we_i),
  .scl_o     (scl_o),
  .sda_o     (sda_o),
  .pending_o (pending_o),
  .irq_o     (irq_o),
  .lrb_o     (lrb_o),
  .err_o     (err_o)
);

// File: tb/i2c_mtx_test.sv
module i2c_mtx_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = '0;
  logic [2:0] bit_cnt_i = '0;
  logic       ack_en_i = 1'b0;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       data_we_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       sda_i = 1'b1;
  logic       scl_o, sda_o, pending_o, irq_o, lrb_o, err_o;

  int nchk = 0;
  int nfail = 0;
  int exp_lrb = 0;

  always #5 clk = ~clk;

  i2c_mtx uut (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div_i), .bit_cnt_i(bit_cnt_i),
    .ack_en_i(ack_en_i), .start_i(start_i), .stop_i(stop_i),
    .data_we_i(data_we_i), .data_i(data_i), .sda_i(sda_i),
    .scl_o(scl_o), .sda_o(sda_o), .pending_o(pending_o), .irq_o(irq_o),
    .lrb_o(lrb_o), .err_o(err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    exp_lrb = 0;
    @(negedge clk);
  endtask

  task automatic do_start();
    int hi = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (scl_o && !sda_o) begin hi++; @(negedge clk); end
    chk("R2 start phase len", hi, int'(div_i) + 1);
    chk("R2 held scl", scl_o, 0);
    chk("R2 held sda", sda_o, 0);
  endtask

  task automatic do_stop();
    int lo = 0;
    int hi = 0;
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    while (!scl_o) begin lo++; @(negedge clk); end
    chk("R9 stop low len", lo, int'(div_i) + 1);
    while (scl_o && !sda_o) begin hi++; @(negedge clk); end
    chk("R9 stop high len", hi, int'(div_i) + 1);
    chk("R9 sda rise scl", scl_o, 1);
    chk("R9 sda rise sda", sda_o, 1);
    repeat (int'(div_i) + 4) @(negedge clk);
    chk("R9 idle lines", {30'd0, scl_o, sda_o}, 3);
  endtask

  task automatic do_xfer(input logic [7:0] d, input int bc, input bit a, input bit ackv, input bit inj);
    int n, cyc, rises, irqbad, viol, expv, mask;
    bit did;
    logic psc, psd;
    logic [15:0] cap;
    n = (bc == 0) ? 8 : bc;
    cyc = 0; rises = 0; irqbad = 0; viol = 0; did = 0; cap = '0;
    sda_i = ackv;
    @(negedge clk);
    data_i = d; bit_cnt_i = 3'(bc); ack_en_i = a; data_we_i = 1'b1;
    @(negedge clk);
    data_we_i = 1'b0;
    chk("R3 pending set", pending_o, 1);
    psc = scl_o; psd = sda_o;
    while (pending_o) begin
      cyc++;
      if (irq_o) irqbad++;
      if (inj && rises == 2 && !did) begin
        data_we_i = 1'b1; data_i = ~d; start_i = 1'b1; stop_i = 1'b1; did = 1;
      end else begin
        data_we_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
      end
      @(negedge clk);
      if (scl_o && !psc) begin rises++; cap = {cap[14:0], sda_o}; end
      if (scl_o && psc && pending_o && sda_o != psd) viol++;
      psc = scl_o; psd = sda_o;
    end
    data_we_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    mask = (1 << (n + int'(a))) - 1;
    expv = int'(d) & ((1 << n) - 1);
    if (a) expv = (expv << 1) | 1;
    chk("R4 scl rising count", rises, n + int'(a));
    chk("R4 bits sent msb first", int'(cap) & mask, expv);
    chk("R3 sda stable while scl high", viol, 0);
    chk("R6 pending length", cyc, 2 * (n + int'(a)) * (int'(div_i) + 1));
    chk("R7 irq at end", irq_o, 1);
    chk("R7 no early irq", irqbad, 0);
    if (a) exp_lrb = int'(ackv);
    chk("R5 lrb", lrb_o, exp_lrb);
    repeat (3) @(negedge clk);
    chk("R7 irq one cycle", irq_o, 0);
    chk("R7 scl held low", scl_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 scl", scl_o, 1);
    chk("R1 sda", sda_o, 1);
    chk("R1 pending", pending_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 lrb", lrb_o, 0);
    chk("R1 err", err_o, 0);

    // R8: write outside the held state
    @(negedge clk); data_we_i = 1'b1; data_i = 8'h5A;
    @(negedge clk); data_we_i = 1'b0;
    chk("R8 idle write pending", pending_o, 0);
    chk("R8 idle write err", err_o, 1);
    chk("R8 idle write scl", scl_o, 1);

    for (int dv = 0; dv < 3; dv++) begin
      do_reset();
      div_i = (dv == 2) ? 8'd3 : 8'(dv);
      do_start();
      // R2: start while held is ignored
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (int'(div_i) + 3) @(negedge clk);
      chk("R2 start in hold ignored", {30'd0, scl_o, sda_o}, 0);
      for (int bc = 0; bc < 8; bc++) begin
        for (int a = 0; a < 2; a++) begin
          do_xfer(8'(8'hA5 ^ (bc * 37) ^ (a * 8'h5C) ^ (dv * 8'h11)),
                  bc, a[0], 1'((bc + a + dv) % 3 == 0), 1'b0);
        end
      end
      chk("R8 no err after legal writes", err_o, 0);
      do_stop();
    end

    // R8/R9: busy write, start and stop injected mid-transfer
    do_reset();
    div_i = 8'd1;
    do_start();
    do_xfer(8'hC3, 0, 1'b1, 1'b1, 1'b1);
    chk("R8 busy write err", err_o, 1);
    do_stop();

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule